// File: doc/BRIEF.md
# Sensor Master Clock Divider

This block derives the clock sent to an image sensor from the chip's master clock. A 5-bit divisor code selects what comes out. Code 0 parks the output low and code 1 parks it high, with the divider idle in both cases. Code 31 passes the master clock straight through. Every code from 2 to 30 divides the master clock by that integer, for both even and odd values.

The code input may change at any time. The block samples it only at the end of the output period in progress, so a period that has started always completes with its old length. The output is registered in every mode except pass-through. The pass-through gate is armed and disarmed on falling master edges, so entering or leaving pass-through never produces a short pulse.

The block is built around one state machine. The states are:

- `ST_HOLD_LO`: static low.
- `ST_HOLD_HI`: static high.
- `ST_RUN_HI`: high phase of a divided period.
- `ST_RUN_LO`: low phase of a divided period.
- `ST_PASS`: pass-through.

The transitions are:

- **load**: from a hold state, from `ST_PASS`, or from the last cycle of `ST_RUN_LO`, the machine decodes the sampled code into the state for that mode.
- **phase-flip**: from the last cycle of `ST_RUN_HI` to `ST_RUN_LO`.
- **count**: the machine stays in a run state while its phase counter advances.

Top module: `xclk_gen`

## Requirements
- R1: While reset is asserted and after it is released with code 0, the active code is 0 and `xclk` is low.
- R2: With code 0 active, `xclk` stays low on every cycle.
- R3: With code 1 active, `xclk` stays high on every cycle.
- R4: With a code N from 2 to 30 active, `xclk` has a period of exactly N master cycles.
- R5: For a code N from 2 to 30, the high phase lasts floor(N/2) master cycles and the low phase lasts N - floor(N/2). The period starts with its high phase.
- R6: With code 31 (all ones) active, `xclk` equals the master clock: high in the high half of each master cycle and low in the low half.
- R7: A new code is sampled only at a period boundary. In a divided mode that boundary is the last cycle of the low phase; in a static or pass-through mode every cycle is a boundary. The period in progress finishes with its old high and low lengths.
- R8: The pass-through gate register changes only on a falling master edge. On leaving pass-through for code 0, `xclk` completes the current master high half and is low from the following falling edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 5 | Divisor code: 0 low, 1 high, 2..30 divide, 31 pass-through |
| xclk | output | 1 | Clock to the sensor |

## Verification
On every cycle the assertions check four things:

- The static modes hold their level.
- The active code only changes right after a boundary cycle.
- Every completed high phase lasts floor(N/2) cycles.
- The pass-through gate is clear whenever the machine has been outside `ST_PASS` for two cycles.

The directed scenarios are needed for the things that depend on the shape of the waveform at the port. These are the measured period of both even and odd divisors, the half-cycle behaviour of pass-through, and a period that finishes with its old length after a mid-period code change. They also cover the clean low level after leaving pass-through.

// File: rtl/xclk_pkg.sv
package xclk_pkg;

    typedef enum logic [2:0] {
        ST_HOLD_LO = 3'd0,
        ST_HOLD_HI = 3'd1,
        ST_RUN_HI  = 3'd2,
        ST_RUN_LO  = 3'd3,
        ST_PASS    = 3'd4
    } xclk_state_t;

endpackage

// File: rtl/xclk_phase.sv
// Splits a divisor into high-phase and low-phase lengths.
module xclk_phase #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] n_div,
    output logic [CODE_W-1:0] hi_len,
    output logic [CODE_W-1:0] lo_len
);

    always_comb begin
        hi_len = n_div >> 1;
        lo_len = n_div - (n_div >> 1);
    end

endmodule

// File: rtl/xclk_fsm.sv
// Mode state machine, phase counter and registered divided output.
module xclk_fsm
    import xclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CODE_W-1:0] hi_len,
    input  logic [CODE_W-1:0] lo_len,
    output xclk_state_t       state,
    output logic [CODE_W-1:0] act_code,
    output logic              at_boundary,
    output logic              div_q
);

    localparam logic [CODE_W-1:0] CODE_LOW  = '0;
    localparam logic [CODE_W-1:0] CODE_HIGH = CODE_W'(1);
    localparam logic [CODE_W-1:0] CODE_BYP  = '1;

    xclk_state_t       nxt_state;
    logic [CODE_W-1:0] cnt, nxt_cnt;
    logic [CODE_W-1:0] nxt_code;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_HOLD_LO;
            cnt      <= '0;
            act_code <= CODE_LOW;
        end else begin
            state    <= nxt_state;
            cnt      <= nxt_cnt;
            act_code <= nxt_code;
        end
    end

    // Next-state logic
    always_comb begin
        nxt_state   = state;
        nxt_cnt     = cnt;
        nxt_code    = act_code;
        at_boundary = 1'b0;
        unique case (state)
            ST_HOLD_LO, ST_HOLD_HI, ST_PASS: at_boundary = 1'b1;
            ST_RUN_HI: begin
                if (cnt == hi_len - 1'b1) begin
                    nxt_state = ST_RUN_LO;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            ST_RUN_LO: begin
                if (cnt == lo_len - 1'b1) at_boundary = 1'b1;
                else                      nxt_cnt     = cnt + 1'b1;
            end
            default: at_boundary = 1'b1;
        endcase
        if (at_boundary) begin
            nxt_code = code_in;
            nxt_cnt  = '0;
            if (code_in == CODE_LOW)       nxt_state = ST_HOLD_LO;
            else if (code_in == CODE_HIGH) nxt_state = ST_HOLD_HI;
            else if (code_in == CODE_BYP)  nxt_state = ST_PASS;
            else                           nxt_state = ST_RUN_HI;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= (nxt_state == ST_RUN_HI) || (nxt_state == ST_HOLD_HI);
    end

endmodule

// File: rtl/xclk_outmux.sv
// Pass-through gate armed on falling edges, merged with the divided output.
module xclk_outmux
    import xclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  xclk_state_t state,
    input  logic        div_q,
    output logic        byp_q,
    output logic        xclk
);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= 1'b0;
        else        byp_q <= (state == ST_PASS);
    end

    assign xclk = div_q | (clk & byp_q);

endmodule

// File: rtl/xclk_gen.sv
module xclk_gen
    import xclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              xclk
);

    xclk_state_t       state;
    logic [CODE_W-1:0] act_code;
    logic [CODE_W-1:0] hi_len, lo_len;
    logic              at_boundary;
    logic              div_q;
    logic              byp_q;

    xclk_phase #(.CODE_W(CODE_W)) u_phase (
        .n_div  (act_code),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    xclk_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_in     (div_code),
        .hi_len      (hi_len),
        .lo_len      (lo_len),
        .state       (state),
        .act_code    (act_code),
        .at_boundary (at_boundary),
        .div_q       (div_q)
    );

    xclk_outmux u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .div_q (div_q),
        .byp_q (byp_q),
        .xclk  (xclk)
    );

endmodule

// File: rtl/xclk_chk.sv
module xclk_chk
    import xclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input xclk_state_t       state,
    input logic [CODE_W-1:0] act_code,
    input logic              at_boundary,
    input logic              div_q,
    input logic              byp_q
);

    logic [CODE_W-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hi_run <= '0;
        else if (state == ST_RUN_HI) hi_run <= hi_run + 1'b1;
        else                        hi_run <= '0;
    end

    // R2
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code == '0 && $past(act_code) == '0) |-> !div_q);

    // R3
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code == CODE_W'(1) && $past(act_code) == CODE_W'(1)) |-> div_q);

    // R7
    code_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> $past(at_boundary));

    // R5
    high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN_LO && $past(state) == ST_RUN_HI) |-> hi_run == (act_code >> 1));

    // R8
    gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PASS && $past(state) != ST_PASS) |-> !byp_q);

endmodule

bind xclk_gen xclk_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .act_code    (act_code),
    .at_boundary (at_boundary),
    .div_q       (div_q),
    .byp_q       (byp_q)
);

// File: tb/sim_xclk_gen.sv
`timescale 1ns/1ps
module sim_xclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] div_code = 5'd0;
    logic       xclk;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    xclk_gen u0 (.clk(clk), .rst_n(rst_n), .div_code(div_code), .xclk(xclk));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic samp(output logic v);
        @(posedge clk); #1; v = xclk;
    endtask

    task automatic set_code(input int c);
        @(negedge clk); div_code = 5'(c);
    endtask

    task automatic find_rise();
        logic p, c;
        samp(p);
        for (int i = 0; i < 200; i++) begin
            samp(c);
            if (!p && c) return;
            p = c;
        end
    endtask

    // counts further samples at level lv; returns total run incl. the one already seen
    task automatic run_len(input logic lv, output int len);
        logic c;
        len = 1;
        for (int i = 0; i < 100; i++) begin
            samp(c);
            if (c != lv) return;
            len++;
        end
    endtask

    task automatic t_reset();
        #1; chk("R1 xclk in reset", xclk, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            logic v; samp(v); chk("R1 xclk after reset", v, 0);
        end
    endtask

    task automatic t_static();
        int ones = 0;
        logic v;
        for (int i = 0; i < 20; i++) begin samp(v); ones += v; end
        chk("R2 code 0 high samples", ones, 0);
        set_code(1); repeat (3) @(posedge clk);
        ones = 0;
        for (int i = 0; i < 20; i++) begin samp(v); ones += v; end
        chk("R3 code 1 high samples", ones, 20);
    endtask

    task automatic t_divide(input int n);
        int h, l;
        set_code(n); repeat (70) @(posedge clk);
        find_rise();
        run_len(1'b1, h);
        run_len(1'b0, l);
        chk($sformatf("R5 high len N=%0d", n), h, n / 2);
        chk($sformatf("R4 period N=%0d", n), h + l, n);
    endtask

    task automatic t_change_mid();
        int h, l, h2, l2;
        set_code(10); repeat (70) @(posedge clk);
        find_rise();
        @(negedge clk); div_code = 5'd4;
        run_len(1'b1, h);
        run_len(1'b0, l);
        run_len(1'b1, h2);
        run_len(1'b0, l2);
        chk("R7 old high kept", h, 5);
        chk("R7 old low kept", l, 5);
        chk("R7 new high", h2, 2);
        chk("R7 new period", h2 + l2, 4);
        set_code(10); repeat (70) @(posedge clk);
        find_rise();
        @(negedge clk); div_code = 5'd0;
        run_len(1'b1, h);
        chk("R7 high kept before hold low", h, 5);
        begin
            int ones = 0; logic v;
            for (int i = 0; i < 40; i++) begin samp(v); ones += v; end
            chk("R2 low after change", ones, 0);
        end
    endtask

    task automatic t_pass();
        int hi_ok = 0, lo_ok = 0;
        set_code(31); repeat (6) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1; hi_ok += xclk;
            @(negedge clk); #1; lo_ok += !xclk;
        end
        chk("R6 high half", hi_ok, 8);
        chk("R6 low half", lo_ok, 8);
        set_code(0);
        @(posedge clk); #1; chk("R8 last high half", xclk, 1);
        @(negedge clk); #1; chk("R8 low after falling edge", xclk, 0);
        @(posedge clk); #1; chk("R8 low next cycle", xclk, 0);
        @(negedge clk); #1; chk("R8 low next half", xclk, 0);
    endtask

    initial begin
        t_reset();
        t_static();
        t_divide(2);
        t_divide(3);
        t_divide(7);
        t_divide(16);
        t_divide(29);
        t_divide(30);
        t_change_mid();
        t_pass();
        t_divide(5);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule